// File: doc/BRIEF.md
# Delayed-Branch Fetch Sequencer

This block sequences instruction fetch for a small pipelined load/store core that uses delayed control transfers. It owns the program counter. It presents one fetch address per cycle. It moves each fetched instruction into an execute stage and, for loads and stores, into a following memory stage. An external decoder supplies the instruction class and the branch target for the word at the current fetch address. The execute logic supplies the branch condition for the instruction that is executing.

A jump, or a conditional branch whose condition holds, changes the program counter only after the instruction behind it has been fetched. That delay-slot instruction always runs to completion and is never flushed. A load or store holds the front of the pipeline for one cycle while its memory phase runs. A control transfer placed inside a delay slot is illegal. The block flags it and continues to fetch in sequence.

Top module: `dbr_seq`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` is 0 and `if_valid`, `ex_valid`, `mem_valid`, `mem_stb` and `slot_err` are all 0.
- R2: Class code 2'b00 (ALU, also used for a no-op) takes a fetch phase and then one execute phase. `ex_addr` shows the fetched address one cycle after the fetch, and `fetch_addr` then steps by 1.
- R3: Class code 2'b01 (load/store) spends one further cycle in the memory phase after its execute cycle. In that cycle `mem_valid` and `mem_stb` are 1, `ex_valid` is 0 and `fetch_addr` keeps its previous value. The held word is executed next.
- R4: `mem_stb` is 1 only in the cycle right after a load/store executed. It never rises for ALU, jump or branch instructions.
- R5: Class code 2'b10 (jump) at address A with target T takes effect after its delay slot. The word at A+1 is executed, and the fetch that follows uses T.
- R6: The delay-slot instruction executes exactly once, whether it is a no-op filler, an ALU operation or a load/store.
- R7: Class code 2'b11 (branch) redirects like a jump when `br_cond` is 1 during its execute cycle. When `br_cond` is 0, execution continues in sequence and the next instruction is not treated as a delay slot.
- R8: A jump or branch executing in a delay slot drives `slot_err` to 1 for that one execute cycle. Its target is ignored, and fetch continues at the next sequential address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_cls | input | 2 | Class of the word at `fetch_addr` (00 ALU, 01 load/store, 10 jump, 11 branch) |
| dec_tgt | input | AW | Control-transfer target of the word at `fetch_addr` |
| br_cond | input | 1 | Branch condition for the instruction in execute |
| fetch_addr | output | AW | Current instruction fetch address |
| if_valid | output | 1 | Fetch stage holds a live fetch |
| ex_valid | output | 1 | Execute stage holds an instruction |
| ex_addr | output | AW | Address of the instruction in execute |
| mem_valid | output | 1 | Memory stage holds a load/store |
| mem_stb | output | 1 | Memory-phase strobe of a load/store |
| slot_err | output | 1 | Control transfer found in a delay slot |

## Verification
The sequencer runs several short programs:
- A straight ALU run checks the plain one-step fetch and the two-phase flow.
- A load/store between ALU words shows the single held fetch and the memory strobe.
- A jump over a tripwire word reproduces the 102-to-105 case and confirms that the slot word runs once while the skipped word never runs.
- A jump with a load/store in its slot, a not-taken branch followed by a taken one, and a jump stacked in a delay slot cover slot stalls, condition handling and the illegal-slot flag.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
    typedef enum logic [1:0] {
        CLS_ALU  = 2'b00,
        CLS_LDST = 2'b01,
        CLS_JMP  = 2'b10,
        CLS_BR   = 2'b11
    } ins_cls_t;
endpackage

// File: rtl/dbr_ctl.sv
module dbr_ctl
    import dbr_pkg::*;
(
    input  logic     ex_v,
    input  ins_cls_t ex_cls,
    input  logic     ex_slot,
    input  logic     br_cond,
    output logic     stall,
    output logic     redir,
    output logic     slot_err
);
    logic is_cti;
    logic cti_go;

    always_comb begin
        is_cti   = (ex_cls == CLS_JMP) || (ex_cls == CLS_BR);
        cti_go   = (ex_cls == CLS_JMP) || ((ex_cls == CLS_BR) && br_cond);
        stall    = ex_v && (ex_cls == CLS_LDST);
        redir    = ex_v && !ex_slot && cti_go;
        slot_err = ex_v && ex_slot && is_cti;
    end
endmodule

// File: rtl/dbr_pc_next.sv
module dbr_pc_next #(
    parameter int AW = 16
) (
    input  logic          fetch_en,
    input  logic          stall,
    input  logic          redir,
    input  logic [AW-1:0] pc_q,
    input  logic [AW-1:0] tgt,
    output logic [AW-1:0] pc_d
);
    localparam logic [AW-1:0] STEP = AW'(1);

    always_comb begin
        if (!fetch_en || stall) begin
            pc_d = pc_q;
        end else if (redir) begin
            pc_d = tgt;
        end else begin
            pc_d = pc_q + STEP;
        end
    end
endmodule

// File: rtl/dbr_seq.sv
module dbr_seq
    import dbr_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    dec_cls,
    input  logic [AW-1:0] dec_tgt,
    input  logic          br_cond,
    output logic [AW-1:0] fetch_addr,
    output logic          if_valid,
    output logic          ex_valid,
    output logic [AW-1:0] ex_addr,
    output logic          mem_valid,
    output logic          mem_stb,
    output logic          slot_err
);
    localparam logic [AW-1:0] ONE = AW'(1);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic          if_v;
        logic          ex_v;
        ins_cls_t      ex_cls;
        logic [AW-1:0] ex_tgt;
        logic [AW-1:0] ex_addr;
        logic          ex_slot;
        logic          mem_v;
    } seq_st_t;

    seq_st_t       st_d, st_q;
    logic          stall, redir, err_w;
    logic [AW-1:0] pc_nx;

    dbr_ctl u_ctl (
        .ex_v    (st_q.ex_v),
        .ex_cls  (st_q.ex_cls),
        .ex_slot (st_q.ex_slot),
        .br_cond (br_cond),
        .stall   (stall),
        .redir   (redir),
        .slot_err(err_w)
    );

    dbr_pc_next #(.AW(AW)) u_pc (
        .fetch_en(st_q.if_v),
        .stall   (stall),
        .redir   (redir),
        .pc_q    (st_q.pc),
        .tgt     (st_q.ex_tgt),
        .pc_d    (pc_nx)
    );

    always_comb begin
        st_d         = st_q;
        st_d.pc      = pc_nx;
        st_d.if_v    = 1'b1;
        st_d.ex_v    = st_q.if_v && !stall;
        st_d.ex_cls  = ins_cls_t'(dec_cls);
        st_d.ex_tgt  = dec_tgt;
        st_d.ex_addr = st_q.pc;
        st_d.ex_slot = redir;
        st_d.mem_v   = stall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fetch_addr = st_q.pc;
    assign if_valid   = st_q.if_v;
    assign ex_valid   = st_q.ex_v;
    assign ex_addr    = st_q.ex_addr;
    assign mem_valid  = st_q.mem_v;
    assign mem_stb    = st_q.mem_v;
    assign slot_err   = err_w;

    // R1: reset state held while reset is low
    always @(posedge clk) begin
        if (!rst_n) begin
            a_reset_idle_r1: assert (fetch_addr == '0 && !if_valid && !ex_valid
                                     && !mem_valid && !slot_err)
                else $error("reset state wrong");
        end
    end

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (if_valid && !stall && !redir) |=> (fetch_addr == $past(fetch_addr) + ONE));

    p_ex_follows_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (if_valid && !stall) |=> (ex_valid && ex_addr == $past(fetch_addr)));

    p_ldst_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && st_q.ex_cls == CLS_LDST)
        |=> (mem_stb && !ex_valid && $stable(fetch_addr)));

    p_mem_only_ldst_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_stb |-> $past(ex_valid && st_q.ex_cls == CLS_LDST));

    p_delay_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redir |=> (fetch_addr == $past(st_q.ex_tgt) && ex_valid
                   && ex_addr == $past(fetch_addr)));

    p_slot_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        slot_err |=> (fetch_addr == $past(fetch_addr) + ONE && !slot_err));
endmodule

// File: tb/dbr_seq_bench.sv
module dbr_seq_bench;
    localparam int AW = 16;
    localparam time CLK_PERIOD = 10ns;
    localparam int PD = 128;
    localparam int LOGN = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    dec_cls;
    logic [AW-1:0] dec_tgt;
    logic          br_cond;
    logic [AW-1:0] fetch_addr, ex_addr;
    logic          if_valid, ex_valid, mem_valid, mem_stb, slot_err;

    logic [1:0] p_cls [PD];
    int         p_tgt [PD];
    logic       p_cnd [PD];

    int fa [LOGN];
    int ea [LOGN];
    logic ev [LOGN];
    logic ms [LOGN];
    int exl [LOGN];
    int n_exec, n_mem, n_err, err_at;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        dec_cls = p_cls[fetch_addr[6:0]];
        dec_tgt = AW'(p_tgt[fetch_addr[6:0]]);
        br_cond = p_cnd[ex_addr[6:0]];
    end

    dbr_seq #(.AW(AW)) u_dbr_seq (
        .clk(clk), .rst_n(rst_n), .dec_cls(dec_cls), .dec_tgt(dec_tgt),
        .br_cond(br_cond), .fetch_addr(fetch_addr), .if_valid(if_valid),
        .ex_valid(ex_valid), .ex_addr(ex_addr), .mem_valid(mem_valid),
        .mem_stb(mem_stb), .slot_err(slot_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int i = 0; i < PD; i++) begin
            p_cls[i] = 2'b00; p_tgt[i] = 0; p_cnd[i] = 1'b0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(fetch_addr == 0, "R1 fetch_addr in reset", int'(fetch_addr), 0);
        chk(!if_valid && !ex_valid && !mem_valid && !mem_stb && !slot_err,
            "R1 valids in reset",
            int'({if_valid, ex_valid, mem_valid, mem_stb, slot_err}), 0);
        rst_n = 1'b1;
    endtask

    task automatic run(input int n);
        n_exec = 0; n_mem = 0; n_err = 0; err_at = -1;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            fa[c] = int'(fetch_addr); ea[c] = int'(ex_addr);
            ev[c] = ex_valid; ms[c] = mem_stb;
            if (ex_valid) begin exl[n_exec] = int'(ex_addr); n_exec++; end
            if (mem_stb) n_mem++;
            if (slot_err) begin n_err++; err_at = int'(ex_addr); end
        end
    endtask

    function automatic int count_exec(input int a);
        int k = 0;
        for (int i = 0; i < n_exec; i++) if (exl[i] == a) k++;
        return k;
    endfunction

    task automatic t_sequential();
        clear_prog();
        do_reset();
        run(8);
        chk(fa[0] == 0, "R2 first fetch", fa[0], 0);
        chk(fa[3] == 3, "R2 fetch step", fa[3], 3);
        chk(ev[1] && ea[1] == 0, "R2 exec after fetch", ea[1], 0);
        chk(n_exec == 7 && exl[6] == 6, "R2 exec order", exl[6], 6);
        chk(n_mem == 0, "R4 no strobe for ALU", n_mem, 0);
    endtask

    task automatic t_ldst();
        clear_prog();
        p_cls[1] = 2'b01;
        do_reset();
        run(7);
        chk(ms[3] == 1'b1, "R3 strobe in memory phase", int'(ms[3]), 1);
        chk(!ev[3], "R3 execute bubble", int'(ev[3]), 0);
        chk(fa[3] == fa[2] && fa[3] == 2, "R3 fetch held", fa[3], 2);
        chk(ev[4] && ea[4] == 2, "R3 held word executes", ea[4], 2);
        chk(n_mem == 1 && !ms[4] && !ms[2], "R4 strobe single cycle", n_mem, 1);
        chk(count_exec(2) == 1, "R3 held word once", count_exec(2), 1);
    endtask

    task automatic t_jump();
        clear_prog();
        p_cls[0] = 2'b10;   p_tgt[0] = 100;
        p_cls[102] = 2'b10; p_tgt[102] = 105;
        p_cls[104] = 2'b10; p_tgt[104] = 0;
        do_reset();
        run(9);
        chk(n_exec == 8, "R5 exec count", n_exec, 8);
        chk(exl[2] == 100, "R5 first redirect target", exl[2], 100);
        chk(fa[5] == 103, "R5 slot fetched after jump", fa[5], 103);
        chk(fa[6] == 105, "R5 target fetched after slot", fa[6], 105);
        chk(exl[5] == 103 && exl[6] == 105, "R5 slot then target", exl[6], 105);
        chk(count_exec(103) == 1, "R6 slot runs once", count_exec(103), 1);
        chk(count_exec(1) == 1, "R6 filler slot runs once", count_exec(1), 1);
        chk(count_exec(104) == 0, "R5 skipped word", count_exec(104), 0);
        chk(n_err == 0, "R8 no error on legal jumps", n_err, 0);
    endtask

    task automatic t_ldst_slot();
        clear_prog();
        p_cls[0] = 2'b10; p_tgt[0] = 10;
        p_cls[1] = 2'b01;
        do_reset();
        run(6);
        chk(n_exec == 4 && exl[1] == 1 && exl[2] == 10, "R6 load/store slot order",
            exl[2], 10);
        chk(count_exec(1) == 1, "R6 load/store slot once", count_exec(1), 1);
        chk(n_mem == 1 && ms[3], "R6 slot memory phase", n_mem, 1);
        chk(fa[3] == 10, "R3 target held during slot stall", fa[3], 10);
    endtask

    task automatic t_branch();
        clear_prog();
        p_cls[0] = 2'b11; p_tgt[0] = 20; p_cnd[0] = 1'b0;
        p_cls[2] = 2'b11; p_tgt[2] = 30; p_cnd[2] = 1'b1;
        do_reset();
        run(7);
        chk(n_exec == 6, "R7 exec count", n_exec, 6);
        chk(exl[1] == 1 && exl[2] == 2, "R7 not-taken falls through", exl[2], 2);
        chk(count_exec(20) == 0, "R7 not-taken target unused", count_exec(20), 0);
        chk(exl[3] == 3 && exl[4] == 30 && exl[5] == 31, "R7 taken after slot",
            exl[4], 30);
        chk(n_err == 0, "R7 branch after not-taken is legal", n_err, 0);
    endtask

    task automatic t_slot_cti();
        clear_prog();
        p_cls[0] = 2'b10; p_tgt[0] = 10;
        p_cls[1] = 2'b10; p_tgt[1] = 20;
        do_reset();
        run(6);
        chk(n_err == 1, "R8 error one cycle", n_err, 1);
        chk(err_at == 1, "R8 error on slot jump", err_at, 1);
        chk(n_exec == 5 && exl[3] == 11 && exl[4] == 12, "R8 sequential after slot jump",
            exl[3], 11);
        chk(count_exec(20) == 0, "R8 slot target ignored", count_exec(20), 0);
    endtask

    initial begin
        clear_prog();
        t_sequential();
        t_ldst();
        t_jump();
        t_ldst_slot();
        t_branch();
        t_slot_cti();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule